// File: doc/BRIEF.md
# Calibrated Real-Time Clock Prescaler

This block turns a 32,768 Hz oscillator enable into a one-second tick and trims the timebase digitally. The trim is a 6-bit value: the low five bits give a magnitude of 0 to 31 and the top bit picks the direction. The block runs a 64-minute correction schedule. In each selected minute it alters only the first second. A faster setting removes 256 oscillator cycles from that second. A slower setting adds 128 cycles.

The divider is built as a free-running 128-cycle stage followed by a counter of 128-cycle half-stages. That pair forms the divide-by-256 stage. Correction acts only on the half-stage counter, so a fixed 512 Hz square wave can be taken from the first stage without being disturbed by calibration. A minute strobe marks the end of each minute, which is also the boundary where a new trim value is taken in. A stop input freezes the whole divider. The calendar counters that consume the tick are outside this block.

Top module: `rtc_cal_prescaler`

## Requirements
- R1: While reset is low and in the first cycle after it, `tick_o`, `min_strobe_o` and `sq512_o` are 0. The minute index and the applied trim both start at 0.
- R2: An uncorrected second lasts exactly 2^(7+HALF_W) counted oscillator cycles. This is 32,768 at the default setting. It holds whatever the sign bit is when the magnitude is 0.
- R3: `min_strobe_o` is a one-cycle pulse. It is raised together with the tick that ends the last of SEC_PER_MIN seconds in a minute, and only with that tick.
- R4: With the sign bit (bit 5) set to 1, the first second of an eligible minute is 256 counted cycles shorter than nominal.
- R5: With the sign bit set to 0 and a nonzero magnitude, the first second of an eligible minute is 128 counted cycles longer than nominal.
- R6: The minute index counts minute strobes since reset, modulo 64. Minute m is eligible when m < 2 × magnitude, where the magnitude is bits 4:0 of the applied trim. Only the first second of an eligible minute is changed.
- R7: `cal_i` is sampled on the cycle that ends a minute. It becomes the applied trim for the following minute only, so a change made in the middle of a minute leaves that minute untouched.
- R8: `sq512_o` toggles once every 32 counted cycles, whatever the trim value.
- R9: While `stop_i` is 1, no cycle is counted. No tick is produced and `sq512_o` holds its value. Counting resumes from the same point when `stop_i` returns to 0.
- R10: A clock cycle with `osc_en_i` low is not counted. Second lengths are measured in counted cycles only.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| osc_en_i | input | 1 | One-cycle enable per 32,768 Hz oscillator period |
| stop_i | input | 1 | Freeze the divider while high |
| cal_i | input | 6 | Trim value: bit 5 is the sign (1 = faster), bits 4:0 are the magnitude |
| tick_o | output | 1 | One-cycle pulse per second |
| min_strobe_o | output | 1 | One-cycle pulse that ends each minute |
| sq512_o | output | 1 | 512 Hz square wave that calibration does not affect |

## Verification
The bench keeps its own model of the minute index and the applied trim. It compares the length of every second and the placement of every minute strobe against that model. This exposes a design that trims the wrong second or applies the wrong step size. It also exposes a design that picks up a trim change mid-minute, or misplaces the eligibility edge at minute 2 × magnitude, minutes 62 and 63, or the wrap to minute 0. The square wave is timed through corrected seconds, so a design that trims the first stage would skew it. Stop and gapped-enable phases catch a divider that counts while it should be frozen.

// File: rtl/rtc_cal_prescaler.sv
module rtc_cal_prescaler #(
  parameter int HALF_W      = 8,
  parameter int SEC_PER_MIN = 60
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       osc_en_i,
  input  logic       stop_i,
  input  logic [5:0] cal_i,
  output logic       tick_o,
  output logic       min_strobe_o,
  output logic       sq512_o
);
  localparam int LOW_W = 7;
  localparam int SEC_W = (SEC_PER_MIN > 1) ? $clog2(SEC_PER_MIN) : 1;
  localparam logic [HALF_W-1:0] HALF_SKIP = HALF_W'(3);

  logic [LOW_W-1:0]  low_q;
  logic [HALF_W-1:0] half_q;
  logic [SEC_W-1:0]  sec_q;
  logic [5:0]        min_q, cal_q;
  logic              fix_done_q;

  wire step     = osc_en_i & ~stop_i;
  wire low_wrap = step & (low_q == '1);
  wire sec_end  = low_wrap & (half_q == '1);
  wire min_end  = sec_end & (sec_q == SEC_W'(SEC_PER_MIN - 1));
  wire eligible = (sec_q == '0) & (min_q < {cal_q[4:0], 1'b0});
  wire fix_now  = low_wrap & eligible & ~fix_done_q & (half_q == '0);

  assign sq512_o = low_q[5];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      low_q        <= '0;
      half_q       <= '0;
      sec_q        <= '0;
      min_q        <= '0;
      cal_q        <= '0;
      fix_done_q   <= 1'b0;
      tick_o       <= 1'b0;
      min_strobe_o <= 1'b0;
    end else begin
      tick_o       <= sec_end;
      min_strobe_o <= min_end;
      if (step) low_q <= low_q + 1'b1;
      if (fix_now) begin
        if (cal_q[5]) half_q <= HALF_SKIP;
      end else if (low_wrap) begin
        half_q <= half_q + 1'b1;
      end
      if (sec_end)      fix_done_q <= 1'b0;
      else if (fix_now) fix_done_q <= 1'b1;
      if (sec_end) sec_q <= min_end ? '0 : sec_q + 1'b1;
      if (min_end) begin
        min_q <= min_q + 1'b1;
        cal_q <= cal_i;
      end
    end
  end

  assert_strobe_with_tick_R3: assert property (@(posedge clk) disable iff (!rst_n)
    min_strobe_o |-> tick_o);

  assert_tick_single_R2: assert property (@(posedge clk) disable iff (!rst_n)
    tick_o |=> !tick_o);

  assert_frozen_when_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !(osc_en_i && !stop_i) |=> $stable(low_q) && $stable(half_q));

  assert_tick_on_stage_wrap_R8: assert property (@(posedge clk) disable iff (!rst_n)
    tick_o |-> (low_q == '0) && (half_q == '0));

  assert_trim_held_mid_minute_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !min_end |=> $stable(cal_q));

  assert_one_fix_per_second_R6: assert property (@(posedge clk) disable iff (!rst_n)
    fix_done_q && !sec_end |=> fix_done_q);
endmodule

// File: tb/rtc_cal_prescaler_tb.sv
module rtc_cal_prescaler_tb_top;
  localparam int HALF_W = 3;
  localparam int SPM    = 2;
  localparam int BASE   = 1 << (7 + HALF_W);

  logic clk = 1'b0, rst_n = 1'b0, osc_en = 1'b0, stop = 1'b0;
  logic [5:0] cal = 6'd0;
  logic tick_o, min_strobe_o, sq512_o;

  int checks = 0, errors = 0;
  bit finished = 0;
  bit run = 0, gap_mode = 0;

  always #4 clk = ~clk;

  rtc_cal_prescaler #(.HALF_W(HALF_W), .SEC_PER_MIN(SPM)) dut_i (
    .clk(clk), .rst_n(rst_n), .osc_en_i(osc_en), .stop_i(stop), .cal_i(cal),
    .tick_o(tick_o), .min_strobe_o(min_strobe_o), .sq512_o(sq512_o));

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (!run) osc_en <= 1'b0;
    else if (gap_mode) osc_en <= ~osc_en;
    else osc_en <= 1'b1;
  end

  logic en_seen = 1'b0;
  logic [5:0] cal_seen = 6'd0;
  always @(posedge clk) begin
    en_seen  <= osc_en && !stop;
    cal_seen <= cal;
  end

  int cnt, sqcnt, bsec, bmin, last_iv, ticks;
  logic [5:0] bcal;
  logic sq_prev;

  always @(negedge clk) begin
    if (!rst_n) begin
      cnt = 0; sqcnt = 0; bsec = 0; bmin = 0; bcal = 6'd0; sq_prev = 1'b0; ticks = 0;
    end else begin
      if (en_seen) begin cnt++; sqcnt++; end
      if (tick_o) begin
        bit elig;
        int exp;
        string tag;
        elig = (bsec == 0) && (bmin < 2 * int'(bcal[4:0]));
        exp = BASE;
        tag = "R2 nominal second (R6 not eligible)";
        if (elig && bcal[5]) begin exp = BASE - 256; tag = "R4 shortened second (R6 eligible)"; end
        if (elig && !bcal[5]) begin exp = BASE + 128; tag = "R5 lengthened second (R6 eligible)"; end
        check(cnt == exp, tag, cnt, exp);
        check(min_strobe_o == (bsec == SPM - 1), "R3 minute strobe placement",
              int'(min_strobe_o), int'(bsec == SPM - 1));
        last_iv = cnt;
        cnt = 0;
        ticks++;
        if (bsec == SPM - 1) begin
          bsec = 0;
          bmin = (bmin + 1) % 64;
          bcal = cal_seen;
        end else bsec++;
      end else if (min_strobe_o) begin
        check(1'b0, "R3 strobe without tick", 1, 0);
      end
      if (sq512_o !== sq_prev) begin
        check(sqcnt == 32, "R8 512 Hz half period", sqcnt, 32);
        sqcnt = 0;
      end
      sq_prev = sq512_o;
    end
  end

  task automatic do_reset();
    run = 0; rst_n = 1'b0;
    repeat (5) @(negedge clk);
    check(tick_o == 0 && min_strobe_o == 0, "R1 strobes low in reset", int'(tick_o | min_strobe_o), 0);
    check(sq512_o == 0, "R1 square wave low in reset", int'(sq512_o), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(tick_o == 0 && sq512_o == 0, "R1 outputs low after reset", int'(tick_o | sq512_o), 0);
    run = 1;
  endtask

  task automatic wait_strobe();
    do begin @(negedge clk); #1; end while (!min_strobe_o);
  endtask

  task automatic wait_tick();
    do begin @(negedge clk); #1; end while (!tick_o);
  endtask

  task automatic t_stop();
    int t0;
    logic sq0;
    bit quiet = 1;
    @(negedge clk);
    stop = 1'b1;
    @(negedge clk);
    t0 = ticks; sq0 = sq512_o;
    repeat (200) begin
      @(negedge clk);
      if (tick_o || sq512_o !== sq0) quiet = 0;
    end
    check(quiet, "R9 divider frozen while stopped", int'(quiet), 1);
    check(ticks == t0, "R9 no tick while stopped", ticks - t0, 0);
    stop = 1'b0;
  endtask

  task automatic t_gaps();
    int t0;
    gap_mode = 1;
    t0 = ticks;
    wait_tick();
    check(ticks == t0 + 1, "R10 tick reached with gapped enable", ticks - t0, 1);
    gap_mode = 0;
  endtask

  task automatic t_mid_minute_change();
    cal = 6'b100000;
    wait_strobe();
    cal = 6'b100010;
    wait_tick();
    check(last_iv == BASE, "R7 mid-minute trim change not applied", last_iv, BASE);
  endtask

  task automatic t_cycle_wrap();
    while (bmin != 58) wait_strobe();
    cal = 6'b011111;
    wait_strobe();
    check(bcal == 6'b011111, "R7 trim applied at minute boundary", int'(bcal), 31);
    while (bmin != 2) wait_strobe();
  endtask

  initial begin
    do_reset();
    repeat (300) @(negedge clk);
    t_stop();
    t_gaps();
    t_mid_minute_change();
    t_cycle_wrap();
    if (!finished) begin
      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (195000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule